// File: doc/BRIEF.md
# Cascaded Interrupt Pending Controller

This block gathers level interrupt requests from a set of main sources and from a smaller set of sub-sources, latches them into pending registers, and reduces them to one serviced request for the processor. Sub-sources are arranged in groups. Each group has its own pending and mask pair and drives one main source. A grouped main source also keeps its own direct request input; the two are ORed together.

Out of all pending main sources that are not masked, a fixed arbiter picks the one with the lowest index. It places that source, as a single bit, in an active register and records the bit position in an index register. The interrupt line to the processor is high whenever the active register is non-zero. A handler reads the index, clears the source-pending bit, then clears the active bit. On the following cycle the arbiter presents the next winner, so the handler can loop until the active register reads zero.

Software reaches all state through a small word-addressed read/write port. Reads are combinational.

Top module: `irq_cascade_ctrl`

## Requirements
- R1: After reset, the main mask reads all ones, the sub mask reads 0x7FF, the source-pending, sub-pending, active and index registers read zero, and `irq` is low.
- R2: A main request that is high at a clock edge sets its source-pending bit at that edge, whether the source is masked or not. While the request stays high, the bit cannot be cleared.
- R3: Writing a 1 to a bit of the source-pending register (word 0) or of the active register (word 2) clears that bit. Writing a 0 leaves the bit unchanged. Writing a 1 to a bit of the active register that is not set has no effect.
- R4: When the active register is empty, the next clock edge loads it with the lowest-indexed source that is both pending and unmasked in the main mask (word 1, where 1 means masked). The active register never holds more than one bit, and it keeps its bit until software clears it.
- R5: The index register (word 3, read-only) holds the position of the active bit, and reads zero while the active register is empty.
- R6: `irq` is high exactly when the active register is non-zero.
- R7: One edge after the active bit is cleared, the next pending unmasked source is loaded. If only the active bit is cleared and the source-pending bit is left set, the same source is loaded again.
- R8: A sub-request that is high at a clock edge sets its bit in the sub-pending register (word 4). Writing a 1 to a bit of word 4 clears it, and writing a 0 has no effect.
- R9: Sub-sources 0–2, 3–5 and 6–8 feed main sources 28, 23 and 15, and sub-sources 9–10 feed main source 31. A pending, unmasked sub-source sets its main source's pending bit one edge after its own pending bit is set.
- R10: A sub-source whose bit in the sub mask (word 5, where 1 means masked) is set does not drive its main source. It stays pending in word 4.
- R11: Register words are at addresses 0 through 5 as given above. A read with `bus_en` high and `bus_wr` low returns the value combinationally, zero-extended. Any other address reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| main_req | input | NUM_MAIN | Level requests of the main sources |
| sub_req | input | NUM_SUB | Level requests of the sub-sources |
| bus_en | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 for write, 0 for read |
| bus_addr | input | ADDR_W | Word address |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, combinational |
| irq | output | 1 | Interrupt request to the processor |

## Verification
Several properties are checked on every cycle:
- The active register is one-hot or zero.
- The index register matches the active bit.
- An active bit holds until a write clears it.
- Each load picks the lowest pending unmasked source.
- Every asserted main request or sub-request is latched into its pending register.
- A rising `irq` has a pending unmasked candidate behind it.

Other behaviour is shown only by the bench's sweeps, because it needs a sequence of bus operations:
- the mapping of each sub-source to its main source;
- the gating by the sub mask;
- the write-1-to-clear and write-0 behaviour;
- the re-arbitration after the handler's clear sequence, including the case where the clears come in the wrong order.

// File: rtl/icc_pkg.sv
package icc_pkg;

  // Word addresses of the register port
  typedef enum logic [2:0] {
    A_SRC     = 3'd0,
    A_MASK    = 3'd1,
    A_ACT     = 3'd2,
    A_IDX     = 3'd3,
    A_SUB     = 3'd4,
    A_SUBMASK = 3'd5
  } icc_addr_e;

  localparam int unsigned GRP_FIELD_W = 8;

endpackage

// File: rtl/icc_sub_cascade.sv
module icc_sub_cascade #(
  parameter int unsigned NUM_MAIN    = 32,
  parameter int unsigned GRP_SIZE    = 3,
  parameter int unsigned NUM_SER_GRP = 3,
  parameter int unsigned TAIL_SUBS   = 2,
  parameter int unsigned NUM_GRP     = NUM_SER_GRP + 1,
  parameter logic [NUM_GRP*8-1:0] GRP_MAIN = 32'h1F0F171C,
  parameter int unsigned NUM_SUB     = NUM_SER_GRP*GRP_SIZE + TAIL_SUBS
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_SUB-1:0]  sub_req,
  input  logic [NUM_SUB-1:0]  sub_clr,
  input  logic                smask_we,
  input  logic [NUM_SUB-1:0]  smask_wdata,
  output logic [NUM_SUB-1:0]  sub_pnd,
  output logic [NUM_SUB-1:0]  sub_mask,
  output logic [NUM_MAIN-1:0] casc
);
  localparam int unsigned SER_SUBS = NUM_SER_GRP * GRP_SIZE;
  localparam int unsigned IDX_W    = $clog2(NUM_MAIN);

  logic [NUM_SUB-1:0] sub_pnd_nx;
  logic [NUM_SUB-1:0] live;

  function automatic int unsigned grp_of(input int unsigned s);
    return (s < SER_SUBS) ? (s / GRP_SIZE) : NUM_SER_GRP;
  endfunction

  function automatic logic [IDX_W-1:0] main_of(input int unsigned g);
    logic [icc_pkg::GRP_FIELD_W-1:0] b;
    b = GRP_MAIN[icc_pkg::GRP_FIELD_W*g +: icc_pkg::GRP_FIELD_W];
    return b[IDX_W-1:0];
  endfunction

  always_comb begin
    sub_pnd_nx = (sub_pnd & ~sub_clr) | sub_req;
    live       = sub_pnd & ~sub_mask;
  end

  always_comb begin
    casc = '0;
    for (int s = 0; s < NUM_SUB; s++) begin
      casc[main_of(grp_of(s))] = casc[main_of(grp_of(s))] | live[s];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sub_pnd <= '0;
    end else begin
      sub_pnd <= sub_pnd_nx;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sub_mask <= '1;
    end else if (smask_we) begin
      sub_mask <= smask_wdata;
    end
  end

endmodule

// File: rtl/icc_src_pend.sv
module icc_src_pend #(
  parameter int unsigned NUM_MAIN = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_MAIN-1:0] req_eff,
  input  logic [NUM_MAIN-1:0] src_clr,
  input  logic                mask_we,
  input  logic [NUM_MAIN-1:0] mask_wdata,
  output logic [NUM_MAIN-1:0] src_pnd,
  output logic [NUM_MAIN-1:0] main_mask,
  output logic [NUM_MAIN-1:0] cand
);
  logic [NUM_MAIN-1:0] src_pnd_nx;

  always_comb begin
    src_pnd_nx = (src_pnd & ~src_clr) | req_eff;
    cand       = src_pnd & ~main_mask;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_pnd <= '0;
    end else begin
      src_pnd <= src_pnd_nx;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      main_mask <= '1;
    end else if (mask_we) begin
      main_mask <= mask_wdata;
    end
  end

endmodule

// File: rtl/icc_arbiter.sv
module icc_arbiter #(
  parameter int unsigned NUM_MAIN = 32,
  parameter int unsigned IDX_W    = $clog2(NUM_MAIN)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_MAIN-1:0] cand,
  input  logic [NUM_MAIN-1:0] act_clr,
  output logic [NUM_MAIN-1:0] act,
  output logic [IDX_W-1:0]    act_idx
);
  logic [NUM_MAIN-1:0] pick;
  logic [IDX_W-1:0]    pick_idx;
  logic                found;
  logic                load;
  logic                kill;
  logic                upd_en;
  logic [NUM_MAIN-1:0] act_nx;
  logic [IDX_W-1:0]    idx_nx;

  // fixed priority: lowest index wins
  always_comb begin
    pick     = '0;
    pick_idx = '0;
    found    = 1'b0;
    for (int k = 0; k < NUM_MAIN; k++) begin
      if (!found && cand[k]) begin
        found    = 1'b1;
        pick[k]  = 1'b1;
        pick_idx = IDX_W'(k);
      end
    end
  end

  always_comb begin
    load   = (act == '0) && found;
    kill   = (act & act_clr) != '0;
    upd_en = load || kill;
    if (load) begin
      act_nx = pick;
      idx_nx = pick_idx;
    end else begin
      act_nx = '0;
      idx_nx = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act     <= '0;
      act_idx <= '0;
    end else if (upd_en) begin
      act     <= act_nx;
      act_idx <= idx_nx;
    end
  end

endmodule

// File: rtl/irq_cascade_ctrl.sv
module irq_cascade_ctrl #(
  parameter int unsigned NUM_MAIN    = 32,
  parameter int unsigned GRP_SIZE    = 3,
  parameter int unsigned NUM_SER_GRP = 3,
  parameter int unsigned TAIL_SUBS   = 2,
  parameter int unsigned NUM_GRP     = NUM_SER_GRP + 1,
  parameter logic [NUM_GRP*8-1:0] GRP_MAIN = 32'h1F0F171C,
  parameter int unsigned NUM_SUB     = NUM_SER_GRP*GRP_SIZE + TAIL_SUBS,
  parameter int unsigned DATA_W      = 32,
  parameter int unsigned ADDR_W      = 3
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_MAIN-1:0] main_req,
  input  logic [NUM_SUB-1:0]  sub_req,
  input  logic                bus_en,
  input  logic                bus_wr,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic [DATA_W-1:0]   bus_wdata,
  output logic [DATA_W-1:0]   bus_rdata,
  output logic                irq
);
  import icc_pkg::*;

  localparam int unsigned IDX_W = $clog2(NUM_MAIN);

  logic [1:0]          rst_sync;
  logic                rst_sync_n;
  logic                wr_go;
  logic                rd_go;
  logic [NUM_MAIN-1:0] src_clr;
  logic [NUM_MAIN-1:0] act_clr;
  logic [NUM_SUB-1:0]  sub_clr;
  logic                mask_we;
  logic                smask_we;
  logic [NUM_MAIN-1:0] casc;
  logic [NUM_MAIN-1:0] req_eff;
  logic [NUM_MAIN-1:0] src_pnd;
  logic [NUM_MAIN-1:0] main_mask;
  logic [NUM_MAIN-1:0] cand;
  logic [NUM_SUB-1:0]  sub_pnd;
  logic [NUM_SUB-1:0]  sub_mask;
  logic [NUM_MAIN-1:0] act;
  logic [IDX_W-1:0]    act_idx;

  // reset: asserts at once, releases on the clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync <= 2'b00;
    end else begin
      rst_sync <= {rst_sync[0], 1'b1};
    end
  end
  assign rst_sync_n = rst_sync[1];

  // write strobes
  always_comb begin
    wr_go    = bus_en && bus_wr;
    rd_go    = bus_en && !bus_wr;
    src_clr  = (wr_go && bus_addr == ADDR_W'(A_SRC)) ? bus_wdata[NUM_MAIN-1:0] : '0;
    act_clr  = (wr_go && bus_addr == ADDR_W'(A_ACT)) ? bus_wdata[NUM_MAIN-1:0] : '0;
    sub_clr  = (wr_go && bus_addr == ADDR_W'(A_SUB)) ? bus_wdata[NUM_SUB-1:0]  : '0;
    mask_we  = wr_go && bus_addr == ADDR_W'(A_MASK);
    smask_we = wr_go && bus_addr == ADDR_W'(A_SUBMASK);
  end

  icc_sub_cascade #(
    .NUM_MAIN(NUM_MAIN), .GRP_SIZE(GRP_SIZE), .NUM_SER_GRP(NUM_SER_GRP),
    .TAIL_SUBS(TAIL_SUBS), .NUM_GRP(NUM_GRP), .GRP_MAIN(GRP_MAIN), .NUM_SUB(NUM_SUB)
  ) u_sub (
    .clk(clk), .rst_n(rst_sync_n), .sub_req(sub_req), .sub_clr(sub_clr),
    .smask_we(smask_we), .smask_wdata(bus_wdata[NUM_SUB-1:0]),
    .sub_pnd(sub_pnd), .sub_mask(sub_mask), .casc(casc)
  );

  assign req_eff = main_req | casc;

  icc_src_pend #(.NUM_MAIN(NUM_MAIN)) u_src (
    .clk(clk), .rst_n(rst_sync_n), .req_eff(req_eff), .src_clr(src_clr),
    .mask_we(mask_we), .mask_wdata(bus_wdata[NUM_MAIN-1:0]),
    .src_pnd(src_pnd), .main_mask(main_mask), .cand(cand)
  );

  icc_arbiter #(.NUM_MAIN(NUM_MAIN), .IDX_W(IDX_W)) u_arb (
    .clk(clk), .rst_n(rst_sync_n), .cand(cand), .act_clr(act_clr),
    .act(act), .act_idx(act_idx)
  );

  assign irq = |act;

  // read port, combinational
  always_comb begin
    bus_rdata = '0;
    if (rd_go) begin
      case (bus_addr)
        ADDR_W'(A_SRC):     bus_rdata = DATA_W'(src_pnd);
        ADDR_W'(A_MASK):    bus_rdata = DATA_W'(main_mask);
        ADDR_W'(A_ACT):     bus_rdata = DATA_W'(act);
        ADDR_W'(A_IDX):     bus_rdata = DATA_W'(act_idx);
        ADDR_W'(A_SUB):     bus_rdata = DATA_W'(sub_pnd);
        ADDR_W'(A_SUBMASK): bus_rdata = DATA_W'(sub_mask);
        default:            bus_rdata = '0;
      endcase
    end
  end

endmodule

// File: rtl/icc_checker.sv
module icc_checker #(
  parameter int unsigned NUM_MAIN = 32,
  parameter int unsigned NUM_SUB  = 11,
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned ADDR_W   = 3,
  parameter int unsigned IDX_W    = $clog2(NUM_MAIN)
) (
  input logic                clk,
  input logic                rst_n,
  input logic [NUM_MAIN-1:0] main_req,
  input logic [NUM_SUB-1:0]  sub_req,
  input logic [NUM_MAIN-1:0] src_pnd,
  input logic [NUM_MAIN-1:0] main_mask,
  input logic [NUM_SUB-1:0]  sub_pnd,
  input logic [NUM_MAIN-1:0] act,
  input logic [IDX_W-1:0]    act_idx,
  input logic                irq,
  input logic                bus_en,
  input logic                bus_wr,
  input logic [ADDR_W-1:0]   bus_addr,
  input logic [DATA_W-1:0]   bus_wdata
);
  logic [NUM_MAIN-1:0] chk_cand;
  logic [NUM_MAIN-1:0] chk_low;
  logic                chk_hit;

  assign chk_cand = src_pnd & ~main_mask;
  assign chk_low  = chk_cand & (~chk_cand + 1'b1);
  assign chk_hit  = bus_en && bus_wr && (bus_addr == ADDR_W'(icc_pkg::A_ACT))
                    && ((bus_wdata[NUM_MAIN-1:0] & act) != '0);

  p_onehot_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(act));

  p_lowest_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(act) == '0 && $past(chk_cand) != '0)
      |-> act == $past(chk_low));

  p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(act) != '0 && !$past(chk_hit)) |-> act == $past(act));

  p_idx_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (act != '0) |-> act[act_idx]);

  p_idx_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (act == '0) |-> act_idx == '0);

  p_src_latch_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> (src_pnd & $past(main_req)) == $past(main_req));

  p_sub_latch_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> (sub_pnd & $past(sub_req)) == $past(sub_req));

  p_irq_cause_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(chk_cand) != '0);

endmodule

bind irq_cascade_ctrl icc_checker #(
  .NUM_MAIN(NUM_MAIN), .NUM_SUB(NUM_SUB), .DATA_W(DATA_W), .ADDR_W(ADDR_W)
) u_icc_chk (
  .clk(clk), .rst_n(rst_sync_n), .main_req(main_req), .sub_req(sub_req),
  .src_pnd(src_pnd), .main_mask(main_mask), .sub_pnd(sub_pnd), .act(act),
  .act_idx(act_idx), .irq(irq), .bus_en(bus_en), .bus_wr(bus_wr),
  .bus_addr(bus_addr), .bus_wdata(bus_wdata)
);

// File: tb/irq_cascade_ctrl_bench.sv
module irq_cascade_ctrl_bench;
  logic        clk;
  logic        rst_n;
  logic [31:0] main_req;
  logic [10:0] sub_req;
  logic        bus_en;
  logic        bus_wr;
  logic [2:0]  bus_addr;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic        irq;

  int n_chk  = 0;
  int n_fail = 0;

  irq_cascade_ctrl u_irq_cascade_ctrl (
    .clk(clk), .rst_n(rst_n), .main_req(main_req), .sub_req(sub_req),
    .bus_en(bus_en), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_en = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_en = 1'b0; bus_wr = 1'b0; bus_wdata = '0;
  endtask

  task automatic chk_reg(input string tag, input logic [2:0] a, input logic [31:0] exp);
    logic [31:0] v;
    bus_en = 1'b1; bus_wr = 1'b0; bus_addr = a;
    #1 v = bus_rdata;
    bus_en = 1'b0;
    chk(tag, v, exp);
  endtask

  task automatic pulse_main(input logic [31:0] bits);
    @(negedge clk); main_req = bits;
    @(negedge clk); main_req = '0;
  endtask

  task automatic pulse_sub(input int s);
    @(negedge clk); sub_req = 11'(1) << s;
    @(negedge clk); sub_req = '0;
  endtask

  function automatic int main_of_sub(input int s);
    if (s < 3) return 28;
    if (s < 6) return 23;
    if (s < 9) return 15;
    return 31;
  endfunction

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; main_req = '0; sub_req = '0;
    bus_en = 1'b0; bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 reset state
    chk_reg("R1 src", 3'd0, 32'h0);
    chk_reg("R1 mask", 3'd1, 32'hFFFF_FFFF);
    chk_reg("R1 act", 3'd2, 32'h0);
    chk_reg("R1 idx", 3'd3, 32'h0);
    chk_reg("R1 sub", 3'd4, 32'h0);
    chk_reg("R1 submask", 3'd5, 32'h7FF);
    chk("R1 irq", 32'(irq), 32'h0);
    chk_reg("R11 unused addr", 3'd6, 32'h0);

    // R2 masked source still pends, no irq
    pulse_main(32'h1 << 5);
    @(negedge clk);
    chk_reg("R2 masked pend", 3'd0, 32'h20);
    chk("R2 masked no irq", 32'(irq), 32'h0);
    // R4 unmasking makes it win one edge later
    wr(3'd1, ~(32'h1 << 5));
    @(negedge clk);
    chk_reg("R4 after unmask", 3'd2, 32'h20);
    wr(3'd0, 32'h20); wr(3'd2, 32'h20);
    wr(3'd1, 32'h0);

    // R4 R5 R6 sweep over every main source
    for (int i = 0; i < 32; i++) begin
      pulse_main(32'h1 << i);
      @(negedge clk);
      chk_reg("R4 single act", 3'd2, 32'h1 << i);
      chk_reg("R5 single idx", 3'd3, 32'(i));
      chk("R6 irq high", 32'(irq), 32'h1);
      wr(3'd0, 32'h1 << i);
      wr(3'd2, 32'h1 << i);
      chk_reg("R3 act cleared", 3'd2, 32'h0);
      chk_reg("R5 idx zero", 3'd3, 32'h0);
      chk("R6 irq low", 32'(irq), 32'h0);
    end

    // R4 R7 priority between pairs
    for (int i = 0; i < 32; i++) begin
      int j;
      int lo;
      int hi;
      j = (i * 7 + 3) % 32;
      if (j != i) begin
        lo = (i < j) ? i : j;
        hi = (i < j) ? j : i;
        pulse_main((32'h1 << i) | (32'h1 << j));
        @(negedge clk);
        chk_reg("R4 lowest wins", 3'd2, 32'h1 << lo);
        wr(3'd0, 32'h1 << lo);
        wr(3'd2, 32'h1 << lo);
        @(negedge clk);
        chk_reg("R7 next winner", 3'd2, 32'h1 << hi);
        chk_reg("R7 next idx", 3'd3, 32'(hi));
        wr(3'd0, 32'h1 << hi);
        wr(3'd2, 32'h1 << hi);
        chk_reg("R7 drained", 3'd2, 32'h0);
      end
    end

    // R3 writing zeros, and a 1 to a clear active bit, changes nothing
    pulse_main(32'h10);
    @(negedge clk);
    wr(3'd2, 32'h0);
    wr(3'd0, 32'h0);
    wr(3'd2, 32'h200);
    chk_reg("R3 act kept", 3'd2, 32'h10);
    chk_reg("R3 src kept", 3'd0, 32'h10);
    wr(3'd0, 32'h10); wr(3'd2, 32'h10);

    // R7 clearing only the active bit reloads the same source
    pulse_main(32'h40);
    @(negedge clk);
    wr(3'd2, 32'h40);
    @(negedge clk);
    chk_reg("R7 reload same", 3'd2, 32'h40);
    wr(3'd0, 32'h40); wr(3'd2, 32'h40);
    chk_reg("R7 empty", 3'd2, 32'h0);

    // R2 held request defeats the clear
    @(negedge clk); main_req = 32'h8;
    wr(3'd0, 32'h8);
    chk_reg("R2 held req", 3'd0, 32'h8);
    main_req = '0;
    wr(3'd0, 32'h8); wr(3'd2, 32'h8);
    chk_reg("R2 cleared", 3'd0, 32'h0);

    // R8 R9 R10 sub-source sweep
    for (int s = 0; s < 11; s++) begin
      int m;
      m = main_of_sub(s);
      pulse_sub(s);
      repeat (2) @(negedge clk);
      chk_reg("R8 sub pend", 3'd4, 32'h1 << s);
      chk_reg("R10 masked no src", 3'd0, 32'h0);
      chk_reg("R10 masked no act", 3'd2, 32'h0);
      wr(3'd4, 32'h0);
      chk_reg("R8 sub w0", 3'd4, 32'h1 << s);
      wr(3'd4, 32'h1 << s);
      chk_reg("R8 sub cleared", 3'd4, 32'h0);
      wr(3'd5, 32'h7FF & ~(32'h1 << s));
      pulse_sub(s);
      repeat (2) @(negedge clk);
      chk_reg("R9 group act", 3'd2, 32'h1 << m);
      chk_reg("R9 group idx", 3'd3, 32'(m));
      wr(3'd4, 32'h1 << s);
      wr(3'd0, 32'h1 << m);
      wr(3'd2, 32'h1 << m);
      chk_reg("R9 drained", 3'd2, 32'h0);
      wr(3'd5, 32'h7FF);
    end
    chk_reg("R11 submask readback", 3'd5, 32'h7FF);

    finish_run();
  end
endmodule